// File: doc/BRIEF.md
# Three-Port Banked Memory Array

This block is a synchronous model of a shared memory split into two equal banks and reached through three independent ports. Each port has its own address, write data, read/write strobe (high reads, low writes) and active-low output enable. The main port selects one of the two banks with a pair of active-low bank enables. The second port is wired to bank 0 only and the third port to bank 1 only, each gated by its own active-low chip enable.

Reads are registered: data leaves the block one clock after the access, together with a valid bit that stands in for a driven (not high-impedance) data bus. While the valid bit is low, the read data is forced to zero. The ports are not arbitrated. When two ports write the same word at the same edge, a fixed priority decides. A read that meets a write to the same word at the same edge returns the old contents. A small two-state power machine reports sleep while the main port and the bank-1 port are both idle.

The power machine has two states. `PWR_RUN` is the state after reset. `PWR_SLEEP` is the sleep state. The transition ENTER goes from `PWR_RUN` to `PWR_SLEEP` when the idle condition is seen at an edge. The transition WAKE goes from `PWR_SLEEP` to `PWR_RUN` when the condition is absent. In all other cases each state holds.

Top module: `tri_port_bank_mem`

## Requirements
- R1: Port 1 with `p1_be0_n`=0 and `p1_be1_n`=1 accesses bank 0. A write (`p1_rw`=0) stores `p1_wdata` at `p1_addr`. A read (`p1_rw`=1, `p1_oe_n`=0) presents the word on `p1_rdata` with `p1_rvalid`=1 one clock later.
- R2: Port 1 with `p1_be1_n`=0 and `p1_be0_n`=1 accesses bank 1 in the same way. Bank 0 and bank 1 hold separate words at the same address.
- R3: Port 2 (`p2_ce_n`=0) always reaches bank 0 and port 3 (`p3_ce_n`=0) always reaches bank 1. Each of them sees the words written to its bank by port 1, and port 1 sees theirs.
- R4: A write cycle stores data and never produces read output. The port's valid bit is 0 in the following cycle, even with its output enable low.
- R5: A port's valid bit is 1 only in the cycle after a cycle in which it was selected, its strobe was high and its output enable was low. Whenever the valid bit is 0, that port's read data is all zeros.
- R6: `p1_be0_n`=0 together with `p1_be1_n`=0 is illegal. It writes neither bank and gives no valid output. It raises `p1_bank_err` in the following cycle only; if the illegal condition persists, the flag stays high.
- R7: If one port reads a word in the same cycle that another port writes it, the read returns the contents from before the write. A later read returns the new value.
- R8: If two ports write the same word of one bank at the same edge, port 1's data is stored.
- R9: `sleep` is 1 in the cycle after an edge at which `p1_be0_n`=1, `p1_be1_n`=1 and `p3_ce_n`=1 (transition ENTER). Otherwise it is 0 (transition WAKE). Port 2's controls have no effect on it.
- R10: While `rst_n` is low, all valid bits, read data, `p1_bank_err` and `sleep` are 0, and the power machine is in `PWR_RUN`.
- R11: Ports writing different addresses of the same bank at the same edge both store their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| p1_be0_n | input | 1 | Port 1 bank 0 enable, active low |
| p1_be1_n | input | 1 | Port 1 bank 1 enable, active low |
| p1_rw | input | 1 | Port 1 strobe, 1 read, 0 write |
| p1_oe_n | input | 1 | Port 1 output enable, active low |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_rdata | output | DATA_W | Port 1 registered read data |
| p1_rvalid | output | 1 | Port 1 read data driven |
| p1_bank_err | output | 1 | Port 1 illegal double bank enable seen |
| p2_ce_n | input | 1 | Port 2 chip enable, active low |
| p2_rw | input | 1 | Port 2 strobe, 1 read, 0 write |
| p2_oe_n | input | 1 | Port 2 output enable, active low |
| p2_addr | input | ADDR_W | Port 2 word address (bank 0) |
| p2_wdata | input | DATA_W | Port 2 write data |
| p2_rdata | output | DATA_W | Port 2 registered read data |
| p2_rvalid | output | 1 | Port 2 read data driven |
| p3_ce_n | input | 1 | Port 3 chip enable, active low |
| p3_rw | input | 1 | Port 3 strobe, 1 read, 0 write |
| p3_oe_n | input | 1 | Port 3 output enable, active low |
| p3_addr | input | ADDR_W | Port 3 word address (bank 1) |
| p3_wdata | input | DATA_W | Port 3 write data |
| p3_rdata | output | DATA_W | Port 3 registered read data |
| p3_rvalid | output | 1 | Port 3 read data driven |
| sleep | output | 1 | Standby indication from the power machine |

## Verification
The bench builds the block with `ADDR_W` = 6 and `DATA_W` = 16, so that each bank holds 64 words. This keeps the arrays small while leaving the address and data paths at full structure. With 64 words, the top word of each bank (address 63) lies within reach of a handful of vectors. The same-word collision, read-before-write and double-enable cases can then be aimed at addresses already loaded with known contents in both banks. The 16-bit data width lets distinct patterns separate bank 0 from bank 1 and port 1's data from the other ports'.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    typedef enum logic {
        PWR_RUN   = 1'b0,
        PWR_SLEEP = 1'b1
    } pwr_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/tpm_port_decode.sv
module tpm_port_decode
    import tpm_pkg::*;
#(
    parameter bit          DUAL      = 1'b0,
    parameter int unsigned HOME_BANK = 0,
    localparam int unsigned EN_W     = DUAL ? 2 : 1
) (
    input  logic [EN_W-1:0] en_n,
    input  logic            rw,
    input  logic            oe_n,
    output acc_e            acc,
    output logic            bank,
    output logic            drive
);

    logic sel;
    logic bad;

    generate
        if (DUAL) begin : g_dual
            always_comb begin
                unique case (en_n)
                    2'b10:   begin sel = 1'b1; bad = 1'b0; bank = 1'b0; end
                    2'b01:   begin sel = 1'b1; bad = 1'b0; bank = 1'b1; end
                    2'b00:   begin sel = 1'b0; bad = 1'b1; bank = 1'b0; end
                    default: begin sel = 1'b0; bad = 1'b0; bank = 1'b0; end
                endcase
            end
        end else begin : g_fixed
            assign sel  = ~en_n[0];
            assign bad  = 1'b0;
            assign bank = 1'(HOME_BANK);
        end
    endgenerate

    always_comb begin
        if (bad)       acc = ACC_BAD;
        else if (!sel) acc = ACC_NONE;
        else if (rw)   acc = ACC_READ;
        else           acc = ACC_WRITE;
    end

    assign drive = (acc == ACC_READ) && !oe_n;

endmodule

// File: rtl/tpm_bank.sv
module tpm_bank #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              b_yield;

    // Channel A (port 1) has priority on a same-word collision.
    assign b_yield = a_we && (a_addr == b_addr);

    always_ff @(posedge clk) begin
        if (b_we && !b_yield) mem[b_addr] <= b_wdata;
        if (a_we)             mem[a_addr] <= a_wdata;
        // Non-blocking reads return the contents from before this edge.
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/tpm_power_fsm.sv
module tpm_power_fsm
    import tpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    output logic sleep
);

    pwr_e state_q;
    pwr_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:   if (idle_req)  state_d = PWR_SLEEP;  // ENTER
            PWR_SLEEP: if (!idle_req) state_d = PWR_RUN;    // WAKE
            default:                  state_d = PWR_RUN;
        endcase
    end

    always_comb begin
        sleep = (state_q == PWR_SLEEP);
    end

endmodule

// File: rtl/tri_port_bank_mem.sv
module tri_port_bank_mem
    import tpm_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p1_be0_n,
    input  logic              p1_be1_n,
    input  logic              p1_rw,
    input  logic              p1_oe_n,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              p1_rvalid,
    output logic              p1_bank_err,
    input  logic              p2_ce_n,
    input  logic              p2_rw,
    input  logic              p2_oe_n,
    input  logic [ADDR_W-1:0] p2_addr,
    input  logic [DATA_W-1:0] p2_wdata,
    output logic [DATA_W-1:0] p2_rdata,
    output logic              p2_rvalid,
    input  logic              p3_ce_n,
    input  logic              p3_rw,
    input  logic              p3_oe_n,
    input  logic [ADDR_W-1:0] p3_addr,
    input  logic [DATA_W-1:0] p3_wdata,
    output logic [DATA_W-1:0] p3_rdata,
    output logic              p3_rvalid,
    output logic              sleep
);

    // Port 1 decode: chooses a bank.
    acc_e p1_acc;
    logic p1_bank;
    logic p1_drive;

    tpm_port_decode #(.DUAL(1'b1), .HOME_BANK(0)) u_dec_p1 (
        .en_n  ({p1_be1_n, p1_be0_n}),
        .rw    (p1_rw),
        .oe_n  (p1_oe_n),
        .acc   (p1_acc),
        .bank  (p1_bank),
        .drive (p1_drive)
    );

    // Fixed ports: index 0 is port 2 (bank 0), index 1 is port 3 (bank 1).
    logic              fx_ce_n  [NUM_BANKS];
    logic              fx_rw    [NUM_BANKS];
    logic              fx_oe_n  [NUM_BANKS];
    logic [ADDR_W-1:0] fx_addr  [NUM_BANKS];
    logic [DATA_W-1:0] fx_wdata [NUM_BANKS];
    logic [DATA_W-1:0] fx_rdata [NUM_BANKS];
    logic              fx_drive [NUM_BANKS];
    logic [DATA_W-1:0] p1_bank_rdata [NUM_BANKS];

    assign fx_ce_n[0]  = p2_ce_n;
    assign fx_rw[0]    = p2_rw;
    assign fx_oe_n[0]  = p2_oe_n;
    assign fx_addr[0]  = p2_addr;
    assign fx_wdata[0] = p2_wdata;
    assign fx_ce_n[1]  = p3_ce_n;
    assign fx_rw[1]    = p3_rw;
    assign fx_oe_n[1]  = p3_oe_n;
    assign fx_addr[1]  = p3_addr;
    assign fx_wdata[1] = p3_wdata;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            acc_e fx_acc;
            logic fx_bank;
            logic fx_we;
            logic p1_we;

            tpm_port_decode #(.DUAL(1'b0), .HOME_BANK(b)) u_dec_fx (
                .en_n  (fx_ce_n[b]),
                .rw    (fx_rw[b]),
                .oe_n  (fx_oe_n[b]),
                .acc   (fx_acc),
                .bank  (fx_bank),
                .drive (fx_drive[b])
            );

            assign fx_we = (fx_acc == ACC_WRITE) && (fx_bank == 1'(b));
            assign p1_we = (p1_acc == ACC_WRITE) && (p1_bank == 1'(b));

            tpm_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
                .clk     (clk),
                .a_we    (p1_we),
                .a_addr  (p1_addr),
                .a_wdata (p1_wdata),
                .b_we    (fx_we),
                .b_addr  (fx_addr[b]),
                .b_wdata (fx_wdata[b]),
                .a_rdata (p1_bank_rdata[b]),
                .b_rdata (fx_rdata[b])
            );
        end
    endgenerate

    // Output qualification registers.
    logic p1_drive_q;
    logic p1_bank_q;
    logic p1_err_q;
    logic p2_drive_q;
    logic p3_drive_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_drive_q <= 1'b0;
            p1_bank_q  <= 1'b0;
            p1_err_q   <= 1'b0;
            p2_drive_q <= 1'b0;
            p3_drive_q <= 1'b0;
        end else begin
            p1_drive_q <= p1_drive;
            p1_bank_q  <= p1_bank;
            p1_err_q   <= (p1_acc == ACC_BAD);
            p2_drive_q <= fx_drive[0];
            p3_drive_q <= fx_drive[1];
        end
    end

    assign p1_rvalid   = p1_drive_q;
    assign p1_bank_err = p1_err_q;
    assign p2_rvalid   = p2_drive_q;
    assign p3_rvalid   = p3_drive_q;
    assign p1_rdata    = p1_drive_q ? p1_bank_rdata[p1_bank_q] : '0;
    assign p2_rdata    = p2_drive_q ? fx_rdata[0] : '0;
    assign p3_rdata    = p3_drive_q ? fx_rdata[1] : '0;

    tpm_power_fsm u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_req (p1_be0_n && p1_be1_n && p3_ce_n),
        .sleep    (sleep)
    );

endmodule

// File: rtl/tri_port_bank_mem_chk.sv
module tri_port_bank_mem_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p1_be0_n,
    input logic              p1_be1_n,
    input logic              p1_rw,
    input logic              p1_oe_n,
    input logic [DATA_W-1:0] p1_rdata,
    input logic              p1_rvalid,
    input logic              p1_bank_err,
    input logic              p2_ce_n,
    input logic              p2_rw,
    input logic              p2_oe_n,
    input logic [DATA_W-1:0] p2_rdata,
    input logic              p2_rvalid,
    input logic              p3_ce_n,
    input logic              p3_rw,
    input logic [DATA_W-1:0] p3_rdata,
    input logic              p3_rvalid,
    input logic              sleep
);

    p_p1_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_rvalid |-> $past(p1_rw && !p1_oe_n && (p1_be0_n != p1_be1_n)));

    p_p2_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        p2_rvalid |-> $past(!p2_ce_n && p2_rw && !p2_oe_n));

    p_p3_no_read_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p3_rvalid |-> $past(!p3_ce_n && p3_rw));

    p_idle_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!p1_rvalid |-> p1_rdata == '0) and (!p2_rvalid |-> p2_rdata == '0)
        and (!p3_rvalid |-> p3_rdata == '0));

    p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p1_bank_err |-> $past(!p1_be0_n && !p1_be1_n));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p1_bank_err |-> !p1_rvalid);

    p_sleep_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> $past(p1_be0_n && p1_be1_n && p3_ce_n));

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(p1_be0_n && p1_be1_n && p3_ce_n) |-> !sleep);

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (!p1_rvalid && !p2_rvalid && !p3_rvalid
                                       && !p1_bank_err && !sleep);
        end
    end

endmodule

bind tri_port_bank_mem tri_port_bank_mem_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p1_be0_n    (p1_be0_n),
    .p1_be1_n    (p1_be1_n),
    .p1_rw       (p1_rw),
    .p1_oe_n     (p1_oe_n),
    .p1_rdata    (p1_rdata),
    .p1_rvalid   (p1_rvalid),
    .p1_bank_err (p1_bank_err),
    .p2_ce_n     (p2_ce_n),
    .p2_rw       (p2_rw),
    .p2_oe_n     (p2_oe_n),
    .p2_rdata    (p2_rdata),
    .p2_rvalid   (p2_rvalid),
    .p3_ce_n     (p3_ce_n),
    .p3_rw       (p3_rw),
    .p3_rdata    (p3_rdata),
    .p3_rvalid   (p3_rvalid),
    .sleep       (sleep)
);

// File: tb/tri_port_bank_mem_bench.sv
module tri_port_bank_mem_bench;

    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          p1_be0_n, p1_be1_n, p1_rw, p1_oe_n;
    logic [AW-1:0] p1_addr;
    logic [DW-1:0] p1_wdata, p1_rdata;
    logic          p1_rvalid, p1_bank_err;
    logic          p2_ce_n, p2_rw, p2_oe_n;
    logic [AW-1:0] p2_addr;
    logic [DW-1:0] p2_wdata, p2_rdata;
    logic          p2_rvalid;
    logic          p3_ce_n, p3_rw, p3_oe_n;
    logic [AW-1:0] p3_addr;
    logic [DW-1:0] p3_wdata, p3_rdata;
    logic          p3_rvalid;
    logic          sleep;

    tri_port_bank_mem #(.ADDR_W(AW), .DATA_W(DW)) u_tri_port_bank_mem (
        .clk(clk), .rst_n(rst_n),
        .p1_be0_n(p1_be0_n), .p1_be1_n(p1_be1_n), .p1_rw(p1_rw), .p1_oe_n(p1_oe_n),
        .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .p1_rvalid(p1_rvalid), .p1_bank_err(p1_bank_err),
        .p2_ce_n(p2_ce_n), .p2_rw(p2_rw), .p2_oe_n(p2_oe_n), .p2_addr(p2_addr),
        .p2_wdata(p2_wdata), .p2_rdata(p2_rdata), .p2_rvalid(p2_rvalid),
        .p3_ce_n(p3_ce_n), .p3_rw(p3_rw), .p3_oe_n(p3_oe_n), .p3_addr(p3_addr),
        .p3_wdata(p3_wdata), .p3_rdata(p3_rdata), .p3_rvalid(p3_rvalid),
        .sleep(sleep)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Vector: {write port, read port, port-1 bank, address, data}
    localparam int VW = 2 + 2 + 1 + AW + DW;
    localparam logic [VW-1:0] VEC [8] = '{
        {2'd1, 2'd1, 1'b0, 6'd0,  16'h1234},
        {2'd1, 2'd2, 1'b0, 6'd63, 16'hA5A5},
        {2'd1, 2'd1, 1'b1, 6'd63, 16'h5A5A},
        {2'd1, 2'd3, 1'b1, 6'd1,  16'hBEEF},
        {2'd2, 2'd1, 1'b0, 6'd2,  16'h0F0F},
        {2'd2, 2'd2, 1'b0, 6'd31, 16'hFFFF},
        {2'd3, 2'd1, 1'b1, 6'd2,  16'hF0F0},
        {2'd3, 2'd3, 1'b1, 6'd32, 16'h8001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic all_idle();
        p1_be0_n = 1; p1_be1_n = 1; p1_rw = 1; p1_oe_n = 1; p1_addr = '0; p1_wdata = '0;
        p2_ce_n = 1;  p2_rw = 1;    p2_oe_n = 1; p2_addr = '0; p2_wdata = '0;
        p3_ce_n = 1;  p3_rw = 1;    p3_oe_n = 1; p3_addr = '0; p3_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one port; kind 0 = write, 1 = read with output enable.
    task automatic drive(input int port, input bit bank, input bit rd,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        case (port)
            1: begin p1_be0_n = bank; p1_be1_n = ~bank; p1_rw = rd; p1_oe_n = ~rd;
                     p1_addr = a; p1_wdata = d; end
            2: begin p2_ce_n = 0; p2_rw = rd; p2_oe_n = ~rd; p2_addr = a; p2_wdata = d; end
            default: begin p3_ce_n = 0; p3_rw = rd; p3_oe_n = ~rd; p3_addr = a; p3_wdata = d; end
        endcase
    endtask

    function automatic logic [DW:0] port_out(input int port);
        case (port)
            1:       return {p1_rvalid, p1_rdata};
            2:       return {p2_rvalid, p2_rdata};
            default: return {p3_rvalid, p3_rdata};
        endcase
    endfunction

    task automatic write1(input int port, input bit bank, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        all_idle(); drive(port, bank, 1'b0, a, d); tick(); all_idle();
    endtask

    task automatic read_chk(input int port, input bit bank, input logic [AW-1:0] a,
                            input logic [DW-1:0] exp, input string req);
        logic [DW:0] got;
        all_idle(); drive(port, bank, 1'b1, a, '0); tick();
        got = port_out(port);
        check(got == {1'b1, exp}, req, 32'(got), 32'({1'b1, exp}));
        all_idle();
    endtask

    initial begin
        all_idle();
        // R10: reset state while inputs request sleep
        repeat (3) @(negedge clk);
        check(!p1_rvalid && !p2_rvalid && !p3_rvalid && p1_rdata == 0 && p2_rdata == 0
              && p3_rdata == 0 && !p1_bank_err && !sleep, "R10 reset outputs",
              {p1_rvalid, p2_rvalid, p3_rvalid, p1_bank_err, sleep}, 32'd0);
        rst_n = 1'b1;
        tick();

        // Vector table: R1 R2 R3
        for (int i = 0; i < 8; i++) begin
            logic [1:0]    wp, rp;
            logic          bk;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            {wp, rp, bk, a, d} = VEC[i];
            write1(int'(wp), bk, a, d);
            read_chk(int'(rp), bk, a, d, "R1 R2 R3 vector");
        end

        // R3: same address in both banks seen through the fixed ports
        write1(1, 1'b0, 6'd9, 16'h1111);
        write1(1, 1'b1, 6'd9, 16'h2222);
        read_chk(2, 1'b0, 6'd9, 16'h1111, "R3 port2 bank0");
        read_chk(3, 1'b1, 6'd9, 16'h2222, "R3 port3 bank1");

        // R4: write with output enable low gives no output
        all_idle(); drive(2, 1'b0, 1'b0, 6'd10, 16'h4444); p2_oe_n = 0; tick();
        check(!p2_rvalid && p2_rdata == 0, "R4 write no output", {p2_rvalid, p2_rdata}, 0);
        read_chk(2, 1'b0, 6'd10, 16'h4444, "R4 write stored");

        // R5: read with output enable high, and deselected read
        all_idle(); drive(1, 1'b0, 1'b1, 6'd9, '0); p1_oe_n = 1; tick();
        check(!p1_rvalid && p1_rdata == 0, "R5 oe high", {p1_rvalid, p1_rdata}, 0);
        all_idle(); p3_rw = 1; p3_oe_n = 0; p3_addr = 6'd9; tick();
        check(!p3_rvalid && p3_rdata == 0, "R5 deselected", {p3_rvalid, p3_rdata}, 0);

        // R6: double bank enable
        all_idle(); p1_be0_n = 0; p1_be1_n = 0; p1_rw = 0; p1_addr = 6'd9;
        p1_wdata = 16'hDEAD; tick();
        check(p1_bank_err && !p1_rvalid, "R6 error raised", {p1_bank_err, p1_rvalid}, 32'h2);
        all_idle(); p1_be0_n = 0; p1_be1_n = 0; p1_rw = 1; p1_oe_n = 0; p1_addr = 6'd9; tick();
        check(p1_bank_err && !p1_rvalid && p1_rdata == 0, "R6 illegal read quiet",
              {p1_bank_err, p1_rvalid, p1_rdata}, 32'h20000);
        all_idle(); tick();
        check(!p1_bank_err, "R6 error clears", p1_bank_err, 0);
        read_chk(1, 1'b0, 6'd9, 16'h1111, "R6 bank0 untouched");
        read_chk(1, 1'b1, 6'd9, 16'h2222, "R6 bank1 untouched");

        // R7: port1 reads while port2 writes the same word
        all_idle(); drive(1, 1'b0, 1'b1, 6'd9, '0); drive(2, 1'b0, 1'b0, 6'd9, 16'h7777); tick();
        check(p1_rvalid && p1_rdata == 16'h1111, "R7 old data", p1_rdata, 16'h1111);
        read_chk(1, 1'b0, 6'd9, 16'h7777, "R7 new data");
        // R7: port3 reads while port1 writes bank1
        all_idle(); drive(3, 1'b1, 1'b1, 6'd9, '0); drive(1, 1'b1, 1'b0, 6'd9, 16'h3333); tick();
        check(p3_rvalid && p3_rdata == 16'h2222, "R7 old data p3", p3_rdata, 16'h2222);
        read_chk(3, 1'b1, 6'd9, 16'h3333, "R7 new data p3");

        // R8: same-word write collisions
        all_idle(); drive(1, 1'b0, 1'b0, 6'd20, 16'hAAAA); drive(2, 1'b0, 1'b0, 6'd20, 16'hBBBB);
        tick();
        read_chk(2, 1'b0, 6'd20, 16'hAAAA, "R8 port1 beats port2");
        all_idle(); drive(1, 1'b1, 1'b0, 6'd20, 16'hCCCC); drive(3, 1'b1, 1'b0, 6'd20, 16'hDDDD);
        tick();
        read_chk(3, 1'b1, 6'd20, 16'hCCCC, "R8 port1 beats port3");

        // R11: different addresses in one bank
        all_idle(); drive(1, 1'b0, 1'b0, 6'd21, 16'h0101); drive(2, 1'b0, 1'b0, 6'd22, 16'h0202);
        tick();
        read_chk(1, 1'b0, 6'd21, 16'h0101, "R11 port1 word");
        read_chk(1, 1'b0, 6'd22, 16'h0202, "R11 port2 word");

        // R9: sleep entry, port2 independence, wake
        all_idle(); tick();
        check(sleep, "R9 enter sleep", sleep, 1);
        all_idle(); drive(2, 1'b0, 1'b1, 6'd22, '0); tick();
        check(sleep && p2_rvalid && p2_rdata == 16'h0202, "R9 port2 no effect",
              {sleep, p2_rvalid}, 32'h3);
        all_idle(); p3_ce_n = 0; tick();
        check(!sleep, "R9 wake on port3", sleep, 0);
        all_idle(); p1_be1_n = 0; tick();
        check(!sleep, "R9 port1 active", sleep, 0);
        all_idle(); tick();
        check(sleep, "R9 re-enter", sleep, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule